// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts what a processor core does. It holds one cycle counter and two event counters, all `CNT_W` bits wide. Each event counter watches one line of a vector of single-cycle event pulses from the core, or one external event input. An 8-bit code in the shared control word picks the source for each event counter. The one control word does several jobs. It turns all counting on and off. It clears the counters. It slows the cycle counter by a power of two. It enables one interrupt per counter and holds the sticky overflow flags.

There is no separate enable per counter. To stop a single event counter, software gives it a code that never fires. One such code is the external input code with the input held low. Software loads a counter with a negative value, so the counter wraps after the period it wants. The wrap sets the counter's flag, and an enabled flag raises the one shared, level-sensitive interrupt. Software reads the control word and writes the same value back. This clears exactly the flags it has seen. It changes nothing else.

The block has a simple register port with a write strobe, a 2-bit address and 32-bit write data. Read data comes back one cycle later.

Top module: `perfmon_unit`

## Requirements
- R1: While control bit 0 (global enable) is 0, no counter changes except through a register write or a clear bit.
- R2: Writing 1 to control bit 1 zeroes both event counters and leaves the cycle counter alone. Writing 1 to bit 2 zeroes the cycle counter and restarts the divider. Both bits read back as 0, and a clear wins over an increment in the same cycle.
- R3: With bit 0 set and bit 3 clear, the cycle counter adds one on every clock edge.
- R4: With bits 0 and 3 set, the cycle counter adds one once per 2^DIV_LOG2 edges (64 by default). After a divider restart, the first increment lands on the 2^DIV_LOG2-th enabled edge.
- R5: An event counter adds one on each edge where its selected pulse line is high. Counter 0 takes its code from bits 27:20 and counter 1 from bits 19:12. Code k below NUM_EVT selects `evt_pulse[k]`. Any other code except the external code never counts.
- R6: Code EXT_CODE (0x20) counts `ext_evt`. While `ext_evt` is low, the counter holds its value even if every pulse line is high.
- R7: A counter that steps from all ones to zero sets its overflow flag. The flags sit at bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter).
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it set. A wrap in the same cycle as a clearing write leaves the flag set.
- R9: `irq` is high in the cycle after any flag is set together with its enable, and low otherwise. The enables are bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter).
- R10: Addresses 1, 2 and 3 load the cycle counter, event counter 0 and event counter 1 with any value. A load wins over an increment in the same cycle.
- R11: Reset zeroes the control word, the counters and `irq`. A read of address 0 returns the control word with bits 1, 2, 7, 11 and 31:28 as 0. `rd_data` shows the addressed register as it was just before the sampling edge.
- R12: A new control value takes effect for counting from the edge after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for `reg_addr` |
| evt_pulse | input | NUM_EVT | Single-cycle event pulses from the core |
| ext_evt | input | 1 | External event input, selected by code EXT_CODE |
| irq | output | 1 | Combined level overflow interrupt |

## Verification
The bench builds the unit with 8-bit counters, eight pulse lines and a divide-by-4 prescaler. With these values every counter can wrap within a few hundred cycles. They also let the bench step the divider through every phase from several run lengths. The bench tries every in-range code on both event counters, plus two codes that are out of range, against a computed pulse pattern. It covers the external code, the clear bits, load priority, and how the flag and interrupt behave on a wrap. That includes the case where a wrap and a clearing write fall in the same cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 8;
  localparam int NEV     = 2;         // event counters
  localparam int NCTR    = NEV + 1;   // flag / enable lanes: ev0, ev1, cycle
  localparam int B_EN    = 0;
  localparam int B_EVCLR = 1;
  localparam int B_CYCLR = 2;
  localparam int B_DIV   = 3;
  localparam int B_IEN   = 4;
  localparam int B_OVF   = 8;
  localparam int SEL0_LO = 20;
  localparam int SEL1_LO = 12;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_EV0  = 2'd2,
    A_EV1  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int NUM_EVT  = 32,
  parameter int SEL_W    = 8,
  parameter int EXT_CODE = 32
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               ext,
  output logic               hit
);
  logic [NUM_EVT-1:0] match;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_match
    assign match[i] = evt[i] && (sel == SEL_W'(i));
  end

  assign hit = (|match) || (ext && (sel == SEL_W'(EXT_CODE)));
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [DIV_LOG2-1:0] q;

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (run)    q <= q + DIV_LOG2'(1);
  end

  assign tick = run && (&q);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + W'(1);
  end

  assign wrap = inc && !ld && !clr && (&cnt);
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 32,
  parameter int DIV_LOG2 = 6,
  parameter int EXT_CODE = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_EVT-1:0]  evt_pulse,
  input  logic                ext_evt,
  output logic                irq
);
  reg_addr_e addr_e;
  assign addr_e = reg_addr_e'(reg_addr);

  logic ctrl_wr, ev_clr, cyc_clr, cyc_ld;
  assign ctrl_wr = reg_wr && (addr_e == A_CTRL);
  assign ev_clr  = ctrl_wr && reg_wdata[B_EVCLR];
  assign cyc_clr = ctrl_wr && reg_wdata[B_CYCLR];
  assign cyc_ld  = reg_wr && (addr_e == A_CYC);

  // control state
  logic            en_q, div_q;
  logic [NCTR-1:0] ien_q, ovf_q;
  logic [SEL_W-1:0] sel_q [NEV];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
      ien_q <= '0;
    end else if (ctrl_wr) begin
      en_q  <= reg_wdata[B_EN];
      div_q <= reg_wdata[B_DIV];
      ien_q <= reg_wdata[B_IEN +: NCTR];
    end
  end

  // event counters
  logic [NEV-1:0]   hit, ev_ld, ev_wrap;
  logic [CNT_W-1:0] ev_cnt [NEV];

  for (genvar g = 0; g < NEV; g++) begin : g_ev
    localparam int LO = (g == 0) ? SEL0_LO : SEL1_LO;

    always_ff @(posedge clk) begin
      if (rst)          sel_q[g] <= '0;
      else if (ctrl_wr) sel_q[g] <= reg_wdata[LO +: SEL_W];
    end

    pmu_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W), .EXT_CODE(EXT_CODE)) u_sel (
      .sel (sel_q[g]),
      .evt (evt_pulse),
      .ext (ext_evt),
      .hit (hit[g])
    );

    assign ev_ld[g] = reg_wr && (reg_addr == 2'(int'(A_EV0) + g));

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clr    (ev_clr),
      .ld     (ev_ld[g]),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .inc    (en_q && hit[g]),
      .cnt    (ev_cnt[g]),
      .wrap   (ev_wrap[g])
    );
  end

  // cycle counter with optional divider
  logic             tick, cyc_inc, cyc_wrap;
  logic [CNT_W-1:0] cyc_cnt;

  pmu_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (cyc_clr || cyc_ld),
    .run  (en_q && div_q),
    .tick (tick)
  );

  assign cyc_inc = en_q && (div_q ? tick : 1'b1);

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst    (rst),
    .clr    (cyc_clr),
    .ld     (cyc_ld),
    .ld_val (reg_wdata[CNT_W-1:0]),
    .inc    (cyc_inc),
    .cnt    (cyc_cnt),
    .wrap   (cyc_wrap)
  );

  // sticky overflow flags: set beats write-one-to-clear
  logic [NCTR-1:0] wrap_vec, ovf_clr;
  assign wrap_vec = {cyc_wrap, ev_wrap};
  assign ovf_clr  = ctrl_wr ? reg_wdata[B_OVF +: NCTR] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= '0;
      irq   <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
      irq   <= |(ovf_q & ien_q);
    end
  end

  // registered read port
  logic [DATA_W-1:0] ctrl_img, rd_nxt;

  always_comb begin
    ctrl_img                      = '0;
    ctrl_img[B_EN]                = en_q;
    ctrl_img[B_DIV]               = div_q;
    ctrl_img[B_IEN +: NCTR]       = ien_q;
    ctrl_img[B_OVF +: NCTR]       = ovf_q;
    ctrl_img[SEL0_LO +: SEL_W]    = sel_q[0];
    ctrl_img[SEL1_LO +: SEL_W]    = sel_q[1];
  end

  always_comb begin
    rd_nxt = '0;
    case (addr_e)
      A_CTRL:  rd_nxt = ctrl_img;
      A_CYC:   rd_nxt[CNT_W-1:0] = cyc_cnt;
      A_EV0:   rd_nxt[CNT_W-1:0] = ev_cnt[0];
      default: rd_nxt[CNT_W-1:0] = ev_cnt[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             irq,
  input logic             en,
  input logic [2:0]       ovf,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [CNT_W-1:0] ev_cnt0,
  input logic [CNT_W-1:0] ev_cnt1,
  input logic             hit0
);
  logic wr_ctrl, wr_cyc, wr_ev0;
  assign wr_ctrl = reg_wr && (reg_addr == 2'd0);
  assign wr_cyc  = reg_wr && (reg_addr == 2'd1);
  assign wr_ev0  = reg_wr && (reg_addr == 2'd2);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_ev0 && !(wr_ctrl && reg_wdata[1])) |=> (ev_cnt0 == $past(ev_cnt0))); // R1

  AST_EVCLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && reg_wdata[1]) |=> (ev_cnt0 == '0 && ev_cnt1 == '0)); // R2

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    !(wr_cyc || (wr_ctrl && reg_wdata[2])) |=>
      (cyc_cnt == $past(cyc_cnt) || cyc_cnt == $past(cyc_cnt) + CNT_W'(1))); // R3

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (en && (&ev_cnt0) && hit0 && !wr_ev0 && !(wr_ctrl && reg_wdata[1])) |=> ovf[0]); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf[0] && !(wr_ctrl && reg_wdata[8])) |=> ovf[0]); // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|ovf)); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_ev0 |=> (ev_cnt0 == $past(reg_wdata[CNT_W-1:0]))); // R10
endmodule

bind perfmon_unit perfmon_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .en        (en_q),
  .ovf       (ovf_q),
  .cyc_cnt   (cyc_cnt),
  .ev_cnt0   (ev_cnt[0]),
  .ev_cnt1   (ev_cnt[1]),
  .hit0      (hit[0])
);

// File: tb/perfmon_unit_test.sv
module perfmon_unit_test;
  localparam int CLK_P    = 10;
  localparam int CNT_W    = 8;
  localparam int NUM_EVT  = 8;
  localparam int DIV_LOG2 = 2;
  localparam int EXT_CODE = 32;
  localparam int DIVN     = 1 << DIV_LOG2;

  logic               clk = 1'b0;
  logic               rst;
  logic               reg_wr;
  logic [1:0]         reg_addr;
  logic [31:0]        reg_wdata;
  logic [31:0]        rd_data;
  logic [NUM_EVT-1:0] evt_pulse;
  logic               ext_evt;
  logic               irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  perfmon_unit #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .DIV_LOG2(DIV_LOG2),
                 .EXT_CODE(EXT_CODE)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .evt_pulse(evt_pulse),
    .ext_evt(ext_evt), .irq(irq)
  );

  // control word: en, div, ien, sel0, sel1, flag clear, ev clear, cyc clear
  function automatic logic [31:0] cw(bit en, bit dv, logic [2:0] ien,
                                     logic [7:0] s0, logic [7:0] s1,
                                     logic [2:0] oc, bit ec, bit cc);
    return {4'b0, s0, s1, 1'b0, oc, 1'b0, ien, dv, cc, ec, en};
  endfunction

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) ^ (i * 5));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // both tasks are entered at a falling edge and return at a falling edge
  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, img;
    rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    evt_pulse = '0; ext_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      check("R11 reset read", v, 32'd0);
    end

    // R3 cycle counter full-rate sweep, R12 write latency
    for (int n = 0; n < 13; n++) begin
      wr_reg(2'd0, cw(1, 0, 0, 8'h21, 8'h21, 0, 0, 1));
      repeat (n) @(negedge clk);
      wr_reg(2'd0, cw(0, 0, 0, 8'h21, 8'h21, 0, 0, 0));
      rd_reg(2'd1, v);
      check("R3 R12 cycle count", v, 32'((n + 1) % 256));
    end

    // R4 divided cycle counter sweep
    for (int n = 0; n < 15; n++) begin
      wr_reg(2'd0, cw(1, 1, 0, 8'h21, 8'h21, 0, 0, 1));
      repeat (n) @(negedge clk);
      wr_reg(2'd0, cw(0, 1, 0, 8'h21, 8'h21, 0, 0, 0));
      rd_reg(2'd1, v);
      check("R4 divided count", v, 32'((n + 1) / DIVN));
    end

    // R5 every code on both counters, including out-of-range codes
    for (int k = 0; k < 2; k++) begin
      for (int code = 0; code < NUM_EVT + 2; code++) begin
        logic [7:0] s0, s1;
        int exp;
        s0 = (k == 0) ? 8'(code) : 8'h21;
        s1 = (k == 1) ? 8'(code) : 8'h21;
        exp = 0;
        wr_reg(2'd0, cw(1, 0, 0, s0, s1, 0, 1, 0));
        for (int i = 0; i < 20; i++) begin
          evt_pulse = pat(i);
          if (code < NUM_EVT) exp += int'(pat(i)[code]);
          @(negedge clk);
        end
        evt_pulse = '0;
        wr_reg(2'd0, cw(0, 0, 0, s0, s1, 0, 0, 0));
        rd_reg(2'(2 + k), v);
        check("R5 selected count", v, 32'(exp));
        rd_reg(2'(3 - k), v);
        check("R5 parked counter", v, 32'd0);
      end
    end

    // R6 external code: counts ext_evt only, frozen while it is low
    wr_reg(2'd0, cw(1, 0, 0, 8'h20, 8'h21, 0, 1, 0));
    evt_pulse = '1;
    for (int i = 0; i < 16; i++) begin
      ext_evt = (i % 3 == 0);
      @(negedge clk);
    end
    ext_evt = 1'b0;
    repeat (10) @(negedge clk);
    evt_pulse = '0;
    wr_reg(2'd0, cw(0, 0, 0, 8'h20, 8'h21, 0, 0, 0));
    rd_reg(2'd2, v);
    check("R6 external count", v, 32'd6);

    // R10 loads, then R1 no counting with global enable off
    wr_reg(2'd1, 32'h33);
    wr_reg(2'd2, 32'h44);
    wr_reg(2'd3, 32'hFFFF_FF55);
    rd_reg(2'd1, v); check("R10 load cycle", v, 32'h33);
    rd_reg(2'd2, v); check("R10 load ev0", v, 32'h44);
    rd_reg(2'd3, v); check("R10 load ev1 truncated", v, 32'h55);
    wr_reg(2'd0, cw(0, 0, 0, 8'h00, 8'h01, 0, 0, 0));
    evt_pulse = '1; ext_evt = 1'b1;
    repeat (10) @(negedge clk);
    evt_pulse = '0; ext_evt = 1'b0;
    rd_reg(2'd1, v); check("R1 cycle held", v, 32'h33);
    rd_reg(2'd2, v); check("R1 ev0 held", v, 32'h44);
    rd_reg(2'd3, v); check("R1 ev1 held", v, 32'h55);

    // R10 load wins over increment
    evt_pulse = 8'h01;
    wr_reg(2'd0, cw(1, 0, 0, 8'h00, 8'h21, 0, 0, 0));
    wr_reg(2'd2, 32'h40);
    evt_pulse = '0;
    wr_reg(2'd1, 32'h80);
    wr_reg(2'd0, cw(0, 0, 0, 8'h00, 8'h21, 0, 0, 0));
    rd_reg(2'd2, v); check("R10 ev0 load priority", v, 32'h40);
    rd_reg(2'd1, v); check("R10 cycle load then count", v, 32'h81);

    // R2 clear bits
    evt_pulse = '1;
    wr_reg(2'd0, cw(1, 0, 0, 8'h00, 8'h01, 0, 0, 0));
    wr_reg(2'd0, cw(1, 0, 0, 8'h00, 8'h01, 0, 1, 0));
    evt_pulse = '0;
    wr_reg(2'd0, cw(0, 0, 0, 8'h00, 8'h01, 0, 0, 0));
    rd_reg(2'd2, v); check("R2 ev0 cleared", v, 32'd0);
    rd_reg(2'd3, v); check("R2 ev1 cleared", v, 32'd0);
    rd_reg(2'd1, v); check("R2 cycle untouched", v, 32'h83);
    wr_reg(2'd0, cw(0, 1, 0, 8'h21, 8'h22, 3'b111, 1, 1));
    rd_reg(2'd0, v); check("R2 R11 control readback", v, cw(0, 1, 0, 8'h21, 8'h22, 0, 0, 0));
    rd_reg(2'd1, v); check("R2 cycle cleared", v, 32'd0);

    // R7 R8 R9 event counter 0 wrap
    wr_reg(2'd2, 32'hFE);
    wr_reg(2'd0, cw(1, 0, 3'b001, 8'h00, 8'h21, 0, 0, 0));
    evt_pulse = 8'h01;
    repeat (2) @(negedge clk);
    evt_pulse = '0;
    wr_reg(2'd0, cw(0, 0, 3'b001, 8'h00, 8'h21, 0, 0, 0));
    check("R9 irq on enabled flag", {31'b0, irq}, 32'd1);
    rd_reg(2'd0, img);
    check("R7 R8 flag bit8 set, zero write keeps it", img, cw(0, 0, 3'b001, 8'h00, 8'h21, 3'b001, 0, 0));
    rd_reg(2'd2, v); check("R7 ev0 wrapped to zero", v, 32'd0);
    wr_reg(2'd0, cw(0, 0, 3'b000, 8'h00, 8'h21, 0, 0, 0));
    @(negedge clk);
    check("R9 irq masked", {31'b0, irq}, 32'd0);
    wr_reg(2'd0, cw(0, 0, 3'b001, 8'h00, 8'h21, 0, 0, 0));
    @(negedge clk);
    check("R9 R8 irq back, flag kept", {31'b0, irq}, 32'd1);
    wr_reg(2'd0, img);
    @(negedge clk);
    check("R8 write-back clears irq", {31'b0, irq}, 32'd0);
    rd_reg(2'd0, v);
    check("R8 write-back clears flag only", v, cw(0, 0, 3'b001, 8'h00, 8'h21, 0, 0, 0));

    // R7 R9 event counter 1 and cycle counter wrap together
    wr_reg(2'd1, 32'hFF);
    wr_reg(2'd3, 32'hFF);
    wr_reg(2'd0, cw(1, 0, 3'b110, 8'h21, 8'h01, 0, 0, 0));
    evt_pulse = 8'h02;
    wr_reg(2'd0, cw(0, 0, 3'b110, 8'h21, 8'h01, 0, 0, 0));
    evt_pulse = '0;
    check("R9 irq latency", {31'b0, irq}, 32'd0);
    rd_reg(2'd0, v);
    check("R7 flags bit9 bit10", v, cw(0, 0, 3'b110, 8'h21, 8'h01, 3'b110, 0, 0));
    check("R9 irq after wrap", {31'b0, irq}, 32'd1);

    // R8 set beats clear in the same cycle
    wr_reg(2'd0, cw(0, 0, 0, 8'h21, 8'h21, 3'b111, 0, 0));
    wr_reg(2'd1, 32'hFF);
    wr_reg(2'd0, cw(1, 0, 0, 8'h21, 8'h21, 0, 0, 0));
    wr_reg(2'd0, cw(0, 0, 0, 8'h21, 8'h21, 3'b100, 0, 0));
    rd_reg(2'd0, v);
    check("R8 set wins over clear", v, cw(0, 0, 0, 8'h21, 8'h21, 3'b100, 0, 0));
    check("R9 no irq when disabled", {31'b0, irq}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule